// File: doc/BRIEF.md
# Interlaced Field Parity Detector

This block decides whether the current interlaced video field is odd or even. It looks at where, inside the current horizontal line, the leading edge of vertical sync arrives. Each line is split into sixteen equal slots. The slot length comes from the clock count of the previous line. A programmable window is set by a lower and an upper slot bound. A sense bit chooses whether a vertical sync edge inside that window marks an even field or an odd field. An edge outside the window gives the opposite answer.

Horizontal and vertical sync arrive as raw, asynchronous levels, each with its own active-level input. Each passes through a two-flop synchronizer. A small configuration register holds the window bounds and the sense bit. The field flag changes only once per vertical sync.

Top module: `field_parity_detector`

## Requirements
- R1: A write strobe loads the 8-bit configuration register. Bits 7:4 are the upper slot bound, bit 3 is the hit sense and bits 2:0 are the lower slot bound.
- R2: After reset the configuration register holds 8'h7A: upper bound 7, sense 1, lower bound 2.
- R3: The line period P is the clock count from one horizontal sync leading edge to the next, and is taken from the previous line. The slot length is L = max(P/16 rounded down, 1). While a vertical sync edge is detected D clocks after the horizontal edge (D >= 1), the slot value is (D-1)/L.
- R4: When a line runs longer than the measured period, the slot value stops at 15 and does not wrap.
- R5: A vertical sync edge is in the window only when lower < slot < upper. Both comparisons are strict, so an edge exactly on either bound is outside.
- R6: An in-window edge sets the flag to the sense bit: 1 means even and 0 means odd.
- R7: An out-of-window edge sets the flag to the inverse of the sense bit.
- R8: Each sync input has an active-level input. A value of 1 treats the raw sync as active high and 0 treats it as active low.
- R9: A vertical sync start is the first clock on which the synchronized, polarity-corrected vertical sync is active after being inactive. The flag changes on the following clock and holds until the next start.
- R10: After reset the field flag reads 0 (odd).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_raw | input | 1 | Raw horizontal sync level |
| vsync_raw | input | 1 | Raw vertical sync level |
| hs_act_high | input | 1 | 1: horizontal sync active high, 0: active low |
| vs_act_high | input | 1 | 1: vertical sync active high, 0: active low |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| field_even | output | 1 | 1: even field, 0: odd field |

## Verification
The window decision is tried with vertical sync edges placed just below, exactly on and just above each bound. This separates strict from non-strict comparison and shows whether the sense bit and its inverse are applied on the correct side. Random line lengths, random edge offsets and random window settings under all four sync polarity combinations show that the slot length follows the previous line and that the active levels are honoured. A line made longer than the measured period, with the edge late in it, distinguishes a slot counter that stops at 15 from one that wraps. Sampling again a few lines after each edge, with no new vertical sync, shows the flag holding its value.

// File: rtl/fpd_pkg.sv
package fpd_pkg;
  localparam int SLOT_W = 4;
  localparam int NUM_SLOTS = 1 << SLOT_W;

  typedef struct packed {
    logic [3:0] slot_hi;
    logic       hit_even;
    logic [2:0] slot_lo;
  } fpd_cfg_t;

  localparam fpd_cfg_t CFG_RESET = 8'h7A;
endpackage

// File: rtl/fpd_sync_edge.sv
module fpd_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  input  logic act_high,
  output logic start_pulse
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;
  logic              active;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= raw_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign active      = chain_q[STAGES-1] ^ ~act_high;
  assign start_pulse = active & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= active;
  end

  // R9: a start is a single-cycle pulse
  p_start_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);
endmodule

// File: rtl/fpd_slot_timer.sv
module fpd_slot_timer #(
  parameter int LINE_W = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     line_start,
  output logic [fpd_pkg::SLOT_W-1:0] slot
);
  import fpd_pkg::*;
  localparam int SUB_W = LINE_W - SLOT_W;
  localparam logic [LINE_W-1:0] LINE_MAX = '1;
  localparam logic [SLOT_W-1:0] SLOT_MAX = '1;

  logic [LINE_W-1:0] line_q, line_d, period_q, period_d;
  logic [SUB_W-1:0]  sub_q, sub_d, len_m1;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              period_en;

  always_comb begin
    len_m1 = (period_q[LINE_W-1:SLOT_W] == '0) ? '0
             : period_q[LINE_W-1:SLOT_W] - 1'b1;
  end

  always_comb begin
    period_en = line_start;
    period_d  = (line_q == LINE_MAX) ? LINE_MAX : line_q + 1'b1;
    if (line_start) begin
      line_d = '0;
      sub_d  = '0;
      slot_d = '0;
    end else begin
      line_d = (line_q == LINE_MAX) ? LINE_MAX : line_q + 1'b1;
      if (sub_q >= len_m1) begin
        sub_d  = '0;
        slot_d = (slot_q == SLOT_MAX) ? SLOT_MAX : slot_q + 1'b1;
      end else begin
        sub_d  = sub_q + 1'b1;
        slot_d = slot_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      sub_q  <= '0;
      slot_q <= '0;
    end else begin
      line_q <= line_d;
      sub_q  <= sub_d;
      slot_q <= slot_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         period_q <= '0;
    else if (period_en) period_q <= period_d;
  end

  assign slot = slot_q;

  // R3: every line restarts at slot 0
  p_slot_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> (slot_q == '0));
  // R4: slot counter stops at its top value within a line
  p_slot_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_q == SLOT_MAX) && !line_start |=> (slot_q == SLOT_MAX));
  // R3: slot never moves by more than one per clock
  p_slot_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start |=> (slot_q == $past(slot_q)) || (slot_q == $past(slot_q) + 1'b1));
endmodule

// File: rtl/fpd_field_decide.sv
module fpd_field_decide (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       vs_start,
  input  logic [fpd_pkg::SLOT_W-1:0] slot,
  input  fpd_pkg::fpd_cfg_t          cfg,
  output logic                       field_even
);
  logic in_win, flag_d, flag_q, flag_en;

  always_comb begin
    in_win  = ({1'b0, cfg.slot_lo} < slot) && (slot < cfg.slot_hi);
    flag_en = vs_start;
    flag_d  = in_win ? cfg.hit_even : ~cfg.hit_even;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign field_even = flag_q;

  // R9: flag holds between vertical sync starts
  p_flag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !vs_start |=> $stable(flag_q));
  // R6: edge strictly inside window gives the sense bit
  p_hit_sense_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vs_start && (slot > {1'b0, cfg.slot_lo}) && (slot < cfg.slot_hi)
      |=> (flag_q == $past(cfg.hit_even)));
  // R5, R7: edge on the lower bound is outside
  p_on_low_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vs_start && (slot == {1'b0, cfg.slot_lo}) |=> (flag_q != $past(cfg.hit_even)));
endmodule

// File: rtl/field_parity_detector.sv
module field_parity_detector #(
  parameter int SYNC_STAGES = 2,
  parameter int LINE_W      = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hsync_raw,
  input  logic       vsync_raw,
  input  logic       hs_act_high,
  input  logic       vs_act_high,
  input  logic       cfg_wr,
  input  logic [7:0] cfg_wdata,
  output logic       field_even
);
  import fpd_pkg::*;

  logic [1:0]        rst_pipe_q;
  logic              rst_int_n;
  logic              hs_start, vs_start;
  logic [SLOT_W-1:0] slot;
  fpd_cfg_t          cfg_q, cfg_d;
  logic              cfg_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  always_comb begin
    cfg_en = cfg_wr;
    cfg_d  = fpd_cfg_t'(cfg_wdata);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  cfg_q <= CFG_RESET;
    else if (cfg_en) cfg_q <= cfg_d;
  end

  fpd_sync_edge #(.STAGES(SYNC_STAGES)) u_hs (
    .clk(clk), .rst_n(rst_int_n), .raw_in(hsync_raw),
    .act_high(hs_act_high), .start_pulse(hs_start));

  fpd_sync_edge #(.STAGES(SYNC_STAGES)) u_vs (
    .clk(clk), .rst_n(rst_int_n), .raw_in(vsync_raw),
    .act_high(vs_act_high), .start_pulse(vs_start));

  fpd_slot_timer #(.LINE_W(LINE_W)) u_timer (
    .clk(clk), .rst_n(rst_int_n), .line_start(hs_start), .slot(slot));

  fpd_field_decide u_decide (
    .clk(clk), .rst_n(rst_int_n), .vs_start(vs_start), .slot(slot),
    .cfg(cfg_q), .field_even(field_even));

  // R1: a write lands in the register on the next clock
  p_cfg_write_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    cfg_wr |=> (cfg_q == $past(cfg_wdata)));
  // R1: without a write the register keeps its value
  p_cfg_hold_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    !cfg_wr |=> $stable(cfg_q));
endmodule

// File: tb/tb_field_parity_detector.sv
module tb_field_parity_detector;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       hsync_raw, vsync_raw, hs_act_high, vs_act_high, cfg_wr;
  logic [7:0] cfg_wdata;
  logic       field_even;

  int total = 0;
  int bad = 0;
  int period = 160;
  int prev_period = 160;
  int hcnt = 0;
  int vs_off = 0;
  int vs_hold = 0;
  bit vs_arm = 0;
  bit vs_level = 0;
  bit hs_level = 0;
  logic [7:0] cfg_model;
  int wd = 0;

  field_parity_detector dut (
    .clk(clk), .rst_n(rst_n), .hsync_raw(hsync_raw), .vsync_raw(vsync_raw),
    .hs_act_high(hs_act_high), .vs_act_high(vs_act_high), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .field_even(field_even));

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (hcnt >= period - 1) begin
      hcnt = 0;
      prev_period = period;
    end else hcnt++;
    hs_level = (hcnt < 4);
    hsync_raw = hs_act_high ? hs_level : ~hs_level;
    if (vs_arm && hcnt == vs_off) begin
      vs_level = 1; vs_hold = 40; vs_arm = 0;
    end else if (vs_hold > 0) begin
      vs_hold--;
      if (vs_hold == 0) vs_level = 0;
    end
    vsync_raw = vs_act_high ? vs_level : ~vs_level;
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 190000) begin
      total++; bad++;
      $display("FAIL watchdog expired: actual=%0d expected=<190000", wd);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic bit exp_even(logic [7:0] c, int p, int off);
    int l, s;
    bit inw;
    l = p / 16;
    if (l < 1) l = 1;
    s = (off - 1) / l;
    if (s > 15) s = 15;
    inw = (int'(c[2:0]) < s) && (s < int'(c[7:4]));
    return inw ? c[3] : ~c[3];
  endfunction

  task automatic check(bit act, bit expv, string req);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, expv);
    end
  endtask

  task automatic wait_lines(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (hcnt != 0) @(negedge clk);
    end
  endtask

  task automatic write_cfg(logic [7:0] v);
    @(negedge clk);
    cfg_wr = 1; cfg_wdata = v;
    @(negedge clk);
    cfg_wr = 0;
    cfg_model = v;
  endtask

  // edge at offset off in the current period; expected uses that line's measured period
  task automatic trial(int off, string req);
    bit e;
    wait_lines(1);
    e = exp_even(cfg_model, period, off);
    vs_arm = 1; vs_off = off;
    while (vs_arm) @(negedge clk);
    repeat (8) @(negedge clk);
    check(field_even, e, req);
    while (vs_hold > 0) @(negedge clk);
  endtask

  initial begin
    bit e;
    rst_n = 0; hs_act_high = 1; vs_act_high = 1; cfg_wr = 0; cfg_wdata = 0;
    hsync_raw = 0; vsync_raw = 0;
    cfg_model = 8'h7A;
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(field_even, 1'b0, "R10 reset flag");
    wait_lines(2);
    // R2 default window lo=2 hi=7 sense=1, L=10
    trial(41, "R2 default in-window slot4");
    trial(21, "R5 on lower bound slot2");
    trial(31, "R5 just above lower bound slot3");
    trial(71, "R5 on upper bound slot7");
    trial(61, "R5 just below upper bound slot6");
    trial(151, "R7 out of window slot15");
    // R1 write new layout: hi=12 sense=0 lo=5
    write_cfg(8'hC5);
    trial(81, "R1 R6 in-window sense0 slot8");
    trial(11, "R1 R7 out-of-window sense0 slot1");
    // R9 hold across lines without a new edge
    e = field_even;
    wait_lines(3);
    check(field_even, e, "R9 hold without vsync");
    // R4 saturation: measured period 160, next line runs 400
    write_cfg(8'hF0);
    wait_lines(1);
    @(negedge clk); while (hcnt != 5) @(negedge clk);
    period = 400;
    e = exp_even(cfg_model, 160, 300);
    vs_arm = 1; vs_off = 300;
    while (vs_arm) @(negedge clk);
    repeat (8) @(negedge clk);
    check(field_even, e, "R4 slot stops at 15");
    while (vs_hold > 0) @(negedge clk);
    // R3 random periods and offsets, R8 polarities
    for (int t = 0; t < 40; t++) begin
      int p, off;
      p = 64 + int'($urandom_range(0, 236));
      off = 1 + int'($urandom_range(0, p - 2));
      hs_act_high = 1'($urandom_range(0, 1));
      vs_act_high = 1'($urandom_range(0, 1));
      write_cfg(8'($urandom_range(0, 255)));
      period = p;
      wait_lines(3);
      trial(off, (t % 2) ? "R3 random line" : "R8 random polarity");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule